// File: doc/BRIEF.md
# Bit-Band Alias Access Unit

This unit sits on the path from one bus master to one slave port. It turns word accesses aimed at two 32 MB alias windows into single-bit operations on the matching 1 MB regions. Each 32-bit word of an alias window stands for exactly one bit of the region it shadows. A read through a window returns that bit in bit 0 of the read data. A write through a window performs a locked read-modify-write of the target word, so the sequence is atomic. Any access outside both windows is forwarded unchanged, in the same cycle.

Both sides use one simple handshake. A requester raises `req` and holds `we`, `addr` and `wdata` steady until it sees `done`. In the `done` cycle the read data and the error flag are valid. The slave may raise `done` in the same cycle as `req`, or any number of cycles later. During the read-modify-write the unit raises `s_lock`, which tells the slave fabric to admit no other master between the two phases.

Top module: `bitband_unit`

## Requirements
- R1: For an access outside both alias windows, the slave request, write enable, address and write data equal the master's. In the same cycle the master sees the slave's done, read data and error, and `s_lock` stays low.
- R2: An address in 0x22000000..0x23FFFFFF with window offset `off` targets the word at 0x20000000 + 4*off[24:7]. The bit number inside that word is off[6:2].
- R3: An address in 0x42000000..0x43FFFFFF maps in the same way onto the word at 0x40000000 + 4*off[24:7], bit off[6:2].
- R4: An alias read issues exactly one slave word read to the target word. It returns the selected bit in master read-data bit 0, with bits 31..1 zero, in the cycle the slave completes.
- R5: An alias write issues one slave read and then one slave write to the same word. The write data equals the word just read, with only the selected bit replaced by master write-data bit 0. The master sees done only when the slave write completes.
- R6: `s_lock` is high in every cycle in which the slave request belongs to an alias sequence, including the write phase.
- R7: A slave error on the read phase ends the sequence with no write. The master sees done with error set and read data zero in that same cycle.
- R8: A slave error on the write phase is returned to the master as done with error set.
- R9: While reset is active and the master is idle, the slave request, `s_lock` and master done are all low.
- R10: Addresses just outside each window (0x21FFFFFC, 0x24000000, 0x41FFFFFC, 0x44000000) pass through as in R1. At most one window decodes any address.
- R11: Address bits 1..0 of an alias access do not affect the target word or bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| m_req | input | 1 | Master request, held until m_done |
| m_we | input | 1 | Master write enable |
| m_addr | input | 32 | Master byte address |
| m_wdata | input | 32 | Master write data |
| m_done | output | 1 | Master transfer complete |
| m_rdata | output | 32 | Master read data, valid with m_done |
| m_err | output | 1 | Master error response, valid with m_done |
| s_req | output | 1 | Slave request |
| s_we | output | 1 | Slave write enable |
| s_addr | output | 32 | Slave byte address |
| s_wdata | output | 32 | Slave write data |
| s_lock | output | 1 | Slave lock held during an alias sequence |
| s_done | input | 1 | Slave transfer complete |
| s_rdata | input | 32 | Slave read data, valid with s_done |
| s_err | input | 1 | Slave error, valid with s_done |

## Verification
In one cycle the unit both completes the read phase of an alias write and decides whether to go on to the write phase. A slave error returned on that read is the case where abort and continue meet. The bench causes this by making its slave model fail reads of one chosen region word and then sending an alias write to a bit of that word. It judges the outcome by the error at the master, by the absence of any slave write, and by a later pass-through read showing the word unchanged. The same word is then made to fail only on writes, and a clean alias write follows, to show that the other paths still work.

// File: rtl/bitband_pkg.sv
// Shared widths, state encoding and translation record for the bit-band unit.
package bitband_pkg;
    localparam int BB_AW     = 32;
    localparam int BB_DW     = 32;
    localparam int BB_IDX_W  = $clog2(BB_DW);
    localparam int BB_LANE_W = $clog2(BB_DW / 8);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WR   = 1'b1
    } seq_state_t;

    typedef struct packed {
        logic                hit;
        logic [BB_AW-1:0]    word_addr;
        logic [BB_IDX_W-1:0] bit_idx;
    } xlat_t;
endpackage

// File: rtl/bitband_window.sv
// One alias window: hit detection and translation to region word and bit.
// Assumes ALIAS_BASE is aligned to 2**ALIAS_LOG2 and REGION_BASE to the region size.
// Receives the address without its byte-lane bits, which alias decoding ignores.
module bitband_window #(
    parameter int              AW         = 32,
    parameter int              IDX_W      = 5,
    parameter int              LANE_W     = 2,
    parameter int              ALIAS_LOG2 = 25,
    parameter logic [AW-1:0]   ALIAS_BASE = '0,
    parameter logic [AW-1:0]   REGION_BASE = '0
) (
    input  logic [AW-1:LANE_W] addr_hi,
    output logic               hit,
    output logic [AW-1:0]      word_addr,
    output logic [IDX_W-1:0]   bit_idx
);
    localparam int WORD_LSB = IDX_W + LANE_W;

    // Compare the window tag and split the offset into word index and bit number.
    always_comb begin
        hit       = (addr_hi[AW-1:ALIAS_LOG2] == ALIAS_BASE[AW-1:ALIAS_LOG2]);
        word_addr = REGION_BASE + (AW'(addr_hi[ALIAS_LOG2-1:WORD_LSB]) << LANE_W);
        bit_idx   = addr_hi[WORD_LSB-1:LANE_W];
    end
endmodule

// File: rtl/bitband_decode.sv
// Instantiates one translator per alias window and picks the hitting one.
// Assumes the windows do not overlap; the first hit wins if they ever do.
module bitband_decode
    import bitband_pkg::*;
#(
    parameter int                            NUM_WIN      = 2,
    parameter int                            ALIAS_LOG2   = 25,
    parameter logic [NUM_WIN-1:0][BB_AW-1:0] ALIAS_BASES  = '0,
    parameter logic [NUM_WIN-1:0][BB_AW-1:0] REGION_BASES = '0
) (
    input  logic [BB_AW-1:0] addr,
    output xlat_t            xlat
);
    logic [NUM_WIN-1:0]  win_hit;
    logic [BB_AW-1:0]    win_addr [NUM_WIN];
    logic [BB_IDX_W-1:0] win_idx  [NUM_WIN];
    logic [BB_LANE_W-1:0] lane_unused;

    assign lane_unused = addr[BB_LANE_W-1:0];

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        bitband_window #(
            .AW         (BB_AW),
            .IDX_W      (BB_IDX_W),
            .LANE_W     (BB_LANE_W),
            .ALIAS_LOG2 (ALIAS_LOG2),
            .ALIAS_BASE (ALIAS_BASES[g]),
            .REGION_BASE(REGION_BASES[g])
        ) u_win (
            .addr_hi  (addr[BB_AW-1:BB_LANE_W]),
            .hit      (win_hit[g]),
            .word_addr(win_addr[g]),
            .bit_idx  (win_idx[g])
        );
    end

    // Select the translation of the first hitting window.
    always_comb begin
        xlat = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (win_hit[w] && !xlat.hit) begin
                xlat.hit       = 1'b1;
                xlat.word_addr = win_addr[w];
                xlat.bit_idx   = win_idx[w];
            end
        end
    end

    // Windows never overlap (R10).
    always_comb begin
        if (!$isunknown(win_hit)) begin
            p_disjoint_r10: assert ($onehot0(win_hit) || (lane_unused != lane_unused));
        end
    end
endmodule

// File: rtl/bitband_merge.sv
// Bit extract and bit insert on one data word, used by both alias phases.
module bitband_merge #(
    parameter int DW    = 32,
    parameter int IDX_W = $clog2(DW)
) (
    input  logic [DW-1:0]    word_in,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             new_bit,
    output logic             cur_bit,
    output logic [DW-1:0]    word_out
);
    logic [DW-1:0] mask;

    // Read the selected bit and build the word with only that bit replaced.
    always_comb begin
        mask     = DW'(1) << bit_idx;
        cur_bit  = word_in[bit_idx];
        word_out = (word_in & ~mask) | (new_bit ? mask : '0);
    end
endmodule

// File: rtl/bitband_seq.sv
// Steers the slave port: pass-through, alias read, or locked read-modify-write.
// Assumes the master holds its request fields stable until m_done.
// The read phase happens in ST_IDLE, and the write phase has its own state.
module bitband_seq
    import bitband_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             m_req,
    input  logic             m_we,
    input  logic [BB_AW-1:0] m_addr,
    input  logic [BB_DW-1:0] m_wdata,
    output logic             m_done,
    output logic [BB_DW-1:0] m_rdata,
    output logic             m_err,
    input  xlat_t            xlat,
    input  logic             cur_bit,
    input  logic [BB_DW-1:0] merged_word,
    output logic             s_req,
    output logic             s_we,
    output logic [BB_AW-1:0] s_addr,
    output logic [BB_DW-1:0] s_wdata,
    output logic             s_lock,
    input  logic             s_done,
    input  logic [BB_DW-1:0] s_rdata,
    input  logic             s_err
);
    seq_state_t       st_q, st_d;
    logic [BB_AW-1:0] wr_addr_q;
    logic [BB_DW-1:0] wr_data_q;
    logic             alias_rd_phase;
    logic             go_write;

    assign alias_rd_phase = (st_q == ST_IDLE) && m_req && xlat.hit;
    assign go_write       = alias_rd_phase && m_we && s_done && !s_err;

    // Drive both ports for the current phase and pick the next state.
    always_comb begin
        st_d    = st_q;
        s_req   = m_req;
        s_we    = m_we;
        s_addr  = m_addr;
        s_wdata = m_wdata;
        s_lock  = 1'b0;
        m_done  = s_done;
        m_rdata = s_rdata;
        m_err   = s_err;
        unique case (st_q)
            ST_IDLE: begin
                if (m_req && xlat.hit) begin
                    s_we    = 1'b0;
                    s_addr  = xlat.word_addr;
                    s_wdata = '0;
                    s_lock  = 1'b1;
                    m_done  = s_done && (s_err || !m_we);
                    m_rdata = (m_we || s_err) ? '0 : BB_DW'(cur_bit);
                    m_err   = s_err;
                    if (go_write) st_d = ST_WR;
                end
            end
            ST_WR: begin
                s_req   = 1'b1;
                s_we    = 1'b1;
                s_addr  = wr_addr_q;
                s_wdata = wr_data_q;
                s_lock  = 1'b1;
                m_done  = s_done;
                m_rdata = '0;
                m_err   = s_err;
                if (s_done) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Hold the target word and its merged value across the write phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else if (go_write) begin
            wr_addr_q <= xlat.word_addr;
            wr_data_q <= merged_word;
        end
    end

    // R1: a request outside the windows goes out unchanged and unlocked.
    p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && m_req && !xlat.hit) |-> (s_req && s_addr == m_addr && s_wdata == m_wdata && !s_lock));

    // R4: an alias read returns only bit 0.
    p_rd_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alias_rd_phase && !m_we && m_done) |-> (m_rdata[BB_DW-1:1] == '0));

    // R5: the write phase is entered only after a clean read phase of an alias write.
    p_enter_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WR && $past(st_q) == ST_IDLE) |-> $past(s_done && !s_err && !s_we && m_we));

    // R5: the master is held off while the write phase is pending.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WR && !s_done) |-> !m_done);

    // R6: the write phase is locked.
    p_lock_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WR) |-> (s_lock && s_req && s_we));

    // R7: a read-phase error never leads to a write phase.
    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alias_rd_phase && s_done && s_err) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/bitband_unit.sv
// Top of the bit-band alias unit: window decode, bit merge and phase sequencer.
// Window 0 shadows the SRAM region and window 1 the peripheral region by default.
module bitband_unit
    import bitband_pkg::*;
#(
    parameter int                            NUM_WIN      = 2,
    parameter int                            ALIAS_LOG2   = 25,
    parameter logic [NUM_WIN-1:0][BB_AW-1:0] ALIAS_BASES  = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_WIN-1:0][BB_AW-1:0] REGION_BASES = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_req,
    input  logic              m_we,
    input  logic [BB_AW-1:0]  m_addr,
    input  logic [BB_DW-1:0]  m_wdata,
    output logic              m_done,
    output logic [BB_DW-1:0]  m_rdata,
    output logic              m_err,
    output logic              s_req,
    output logic              s_we,
    output logic [BB_AW-1:0]  s_addr,
    output logic [BB_DW-1:0]  s_wdata,
    output logic              s_lock,
    input  logic              s_done,
    input  logic [BB_DW-1:0]  s_rdata,
    input  logic              s_err
);
    xlat_t            xlat;
    logic             cur_bit;
    logic [BB_DW-1:0] merged_word;

    bitband_decode #(
        .NUM_WIN     (NUM_WIN),
        .ALIAS_LOG2  (ALIAS_LOG2),
        .ALIAS_BASES (ALIAS_BASES),
        .REGION_BASES(REGION_BASES)
    ) u_decode (
        .addr(m_addr),
        .xlat(xlat)
    );

    bitband_merge #(
        .DW   (BB_DW),
        .IDX_W(BB_IDX_W)
    ) u_merge (
        .word_in (s_rdata),
        .bit_idx (xlat.bit_idx),
        .new_bit (m_wdata[0]),
        .cur_bit (cur_bit),
        .word_out(merged_word)
    );

    bitband_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .m_req      (m_req),
        .m_we       (m_we),
        .m_addr     (m_addr),
        .m_wdata    (m_wdata),
        .m_done     (m_done),
        .m_rdata    (m_rdata),
        .m_err      (m_err),
        .xlat       (xlat),
        .cur_bit    (cur_bit),
        .merged_word(merged_word),
        .s_req      (s_req),
        .s_we       (s_we),
        .s_addr     (s_addr),
        .s_wdata    (s_wdata),
        .s_lock     (s_lock),
        .s_done     (s_done),
        .s_rdata    (s_rdata),
        .s_err      (s_err)
    );

    // R9: an idle master never causes slave traffic or a lock.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_req && !$past(m_req)) |-> (!s_req && !s_lock));
endmodule

// File: tb/bitband_unit_test.sv
module bitband_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_req = 1'b0, m_we = 1'b0;
    logic [31:0] m_addr = '0, m_wdata = '0;
    logic        m_done, m_err;
    logic [31:0] m_rdata;
    logic        s_req, s_we, s_lock;
    logic [31:0] s_addr, s_wdata;
    logic        s_done, s_err;
    logic [31:0] s_rdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    bitband_unit uut (
        .clk(clk), .rst_n(rst_n),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_done(m_done), .m_rdata(m_rdata), .m_err(m_err),
        .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
        .s_lock(s_lock), .s_done(s_done), .s_rdata(s_rdata), .s_err(s_err)
    );

    // Slave model: a few tagged words, done on alternate cycles, one error trap.
    localparam int NM = 7;
    logic [31:0] tags [NM] = '{32'h2000_0000, 32'h2000_0010, 32'h4000_0100, 32'h3000_0000,
                               32'h3000_0004, 32'h2400_0000, 32'h200F_FFFC};
    logic [31:0] mem [NM];
    logic        go;
    logic        err_en = 1'b0, err_on_we = 1'b0;
    logic [31:0] err_addr = '0;
    int          rd_cnt = 0, wr_cnt = 0;
    logic [31:0] last_addr = '0, last_wdata = '0;
    logic        lock_and = 1'b1, lock_or = 1'b0;

    assign s_done = s_req && go;
    assign s_err  = s_done && err_en && (s_addr == err_addr) && (s_we == err_on_we);

    always_comb begin
        s_rdata = '0;
        for (int i = 0; i < NM; i++) if (tags[i] == s_addr) s_rdata = mem[i];
    end

    always @(posedge clk) begin
        if (!rst_n) go <= 1'b0;
        else        go <= !go;
        if (rst_n && s_req) begin
            lock_and = lock_and & s_lock;
            lock_or  = lock_or | s_lock;
        end
        if (rst_n && s_req && s_done) begin
            last_addr = s_addr;
            if (s_we) begin
                wr_cnt++;
                last_wdata = s_wdata;
                if (!s_err)
                    for (int i = 0; i < NM; i++) if (tags[i] == s_addr) mem[i] = s_wdata;
            end else begin
                rd_cnt++;
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // One master access; returns read data, error and the slave transfer counts it caused.
    task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wdata,
                          output logic [31:0] rd, output logic err, output int nrd, output int nwr);
        int r0, w0;
        @(negedge clk);
        r0 = rd_cnt; w0 = wr_cnt;
        lock_and = 1'b1; lock_or = 1'b0;
        m_req = 1'b1; m_we = we; m_addr = addr; m_wdata = wdata;
        rd = '0; err = 1'b0;
        for (int n = 0; n < 50; n++) begin
            #1;
            if (m_done) begin
                rd = m_rdata; err = m_err;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        m_req = 1'b0; m_we = 1'b0;
        nrd = rd_cnt - r0; nwr = wr_cnt - w0;
    endtask

    typedef struct packed {
        logic [3:0]  req;
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic [1:0]  nrd;
        logic [1:0]  nwr;
        logic [31:0] saddr;
        logic [31:0] swdata;
        logic        lock;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{4'd4,  1'b0, 32'h2200_0010, 32'h0,         32'h1,         2'd1, 2'd0, 32'h2000_0000, 32'h0,         1'b1}, // R4 bit 4
        '{4'd4,  1'b0, 32'h2200_000C, 32'h0,         32'h0,         2'd1, 2'd0, 32'h2000_0000, 32'h0,         1'b1}, // R4 bit 3
        '{4'd2,  1'b0, 32'h2200_027C, 32'h0,         32'h1,         2'd1, 2'd0, 32'h2000_0010, 32'h0,         1'b1}, // R2 bit 31
        '{4'd5,  1'b1, 32'h2200_0000, 32'h1,         32'h0,         2'd1, 2'd1, 32'h2000_0000, 32'h0000_00F1, 1'b1}, // R5 set
        '{4'd5,  1'b1, 32'h2200_001C, 32'hFFFF_FFFE, 32'h0,         2'd1, 2'd1, 32'h2000_0000, 32'h0000_0071, 1'b1}, // R5 clear
        '{4'd3,  1'b1, 32'h4200_2024, 32'h1,         32'h0,         2'd1, 2'd1, 32'h4000_0100, 32'h0000_0200, 1'b1}, // R3 write
        '{4'd3,  1'b0, 32'h4200_2024, 32'h0,         32'h1,         2'd1, 2'd0, 32'h4000_0100, 32'h0,         1'b1}, // R3 read
        '{4'd11, 1'b0, 32'h4200_2027, 32'h0,         32'h1,         2'd1, 2'd0, 32'h4000_0100, 32'h0,         1'b1}, // R11 lane bits
        '{4'd1,  1'b0, 32'h3000_0000, 32'h0,         32'h1234_5678, 2'd1, 2'd0, 32'h3000_0000, 32'h0,         1'b0}, // R1 read
        '{4'd1,  1'b1, 32'h3000_0004, 32'hCAFE_F00D, 32'h0,         2'd0, 2'd1, 32'h3000_0004, 32'hCAFE_F00D, 1'b0}, // R1 write
        '{4'd10, 1'b0, 32'h21FF_FFFC, 32'h0,         32'h0,         2'd1, 2'd0, 32'h21FF_FFFC, 32'h0,         1'b0}, // R10 below
        '{4'd10, 1'b1, 32'h2400_0000, 32'h55,        32'h0,         2'd0, 2'd1, 32'h2400_0000, 32'h55,        1'b0}, // R10 above
        '{4'd10, 1'b0, 32'h41FF_FFFC, 32'h0,         32'h0,         2'd1, 2'd0, 32'h41FF_FFFC, 32'h0,         1'b0}, // R10 below
        '{4'd10, 1'b0, 32'h4400_0000, 32'h0,         32'h0,         2'd1, 2'd0, 32'h4400_0000, 32'h0,         1'b0}, // R10 above
        '{4'd2,  1'b0, 32'h23FF_FFFC, 32'h0,         32'h0,         2'd1, 2'd0, 32'h200F_FFFC, 32'h0,         1'b1}  // R2 last word
    };

    // Watchdog: a hung run is counted as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic        err;
        int          nrd, nwr;
        string       tag;
        mem = '{32'h0000_00F0, 32'h8000_0001, 32'h0, 32'h1234_5678, 32'h0, 32'h0, 32'h0};

        // R9: quiet outputs under reset with an idle master.
        repeat (3) @(negedge clk);
        chk("R9", "s_req in reset", {31'b0, s_req}, 32'h0);
        chk("R9", "s_lock in reset", {31'b0, s_lock}, 32'h0);
        chk("R9", "m_done in reset", {31'b0, m_done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "s_req after reset", {31'b0, s_req}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
            access(VECS[v].we, VECS[v].addr, VECS[v].wdata, rd, err, nrd, nwr);
            chk(tag, "rdata", rd, VECS[v].exp_rd);
            chk(tag, "err", {31'b0, err}, 32'h0);
            chk(tag, "slave reads", nrd, 32'(VECS[v].nrd));
            chk(tag, "slave writes", nwr, 32'(VECS[v].nwr));
            chk(tag, "slave addr", last_addr, VECS[v].saddr);
            if (VECS[v].nwr != 0) chk(tag, "slave wdata", last_wdata, VECS[v].swdata);
            // R6: lock level held in every slave cycle of the access.
            chk(tag, "lock all cycles (R6)", {30'b0, lock_and, lock_or}, VECS[v].lock ? 32'h3 : 32'h0);
        end

        // R7: read-phase error on an alias write aborts before any write.
        err_en = 1'b1; err_addr = 32'h2000_0010; err_on_we = 1'b0;
        access(1'b1, 32'h2200_0204, 32'h1, rd, err, nrd, nwr);
        chk("R7", "err on rd phase", {31'b0, err}, 32'h1);
        chk("R7", "no write issued", nwr, 0);
        chk("R7", "rdata zero", rd, 32'h0);
        access(1'b0, 32'h2200_0200, 32'h0, rd, err, nrd, nwr);
        chk("R7", "alias read err", {31'b0, err}, 32'h1);
        chk("R7", "alias read err rdata", rd, 32'h0);
        err_en = 1'b0;
        access(1'b0, 32'h2000_0010, 32'h0, rd, err, nrd, nwr);
        chk("R7", "word unchanged", rd, 32'h8000_0001);

        // R8: write-phase error is reported.
        err_en = 1'b1; err_on_we = 1'b1;
        access(1'b1, 32'h2200_0204, 32'h1, rd, err, nrd, nwr);
        chk("R8", "err on wr phase", {31'b0, err}, 32'h1);
        chk("R8", "read then write", {nrd[15:0], nwr[15:0]}, 32'h0001_0001);
        err_en = 1'b0;

        // R5: a clean alias write then lands only the selected bit.
        access(1'b1, 32'h2200_0204, 32'h1, rd, err, nrd, nwr);
        chk("R5", "clean write err", {31'b0, err}, 32'h0);
        access(1'b0, 32'h2000_0010, 32'h0, rd, err, nrd, nwr);
        chk("R5", "word after rmw", rd, 32'h8000_0003);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule